// File: doc/BRIEF.md
# Working Register File with Pointer Pairs and Data-Space Alias

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. The execute stage reads two independent bytes through two combinational read ports and a 16-bit register pair through a third. It writes results back as a single byte or as a 16-bit pair. Every read completes in the same cycle it is requested. Every write lands on the next rising clock edge.

The six highest registers are grouped into three 16-bit address pointers (X, Y and Z), and the block drives these onto dedicated outputs. In each pointer the even register holds the low byte and the odd register holds the high byte.

A load/store path can also reach the file through a linear 16-bit data address. Addresses 0x00 to 0x1F select register n directly. Addresses 0x20 to 0x5F are routed to an external I/O port with the offset rebased to 0. Addresses from 0x60 upward are forwarded unchanged to a memory-side port. Read data for the data-space path returns combinationally from whichever target was selected.

Top module: `gpr_file`

## Requirements
- R1: After reset every register reads 0 on all read ports, and all three pointer outputs are 0.
- R2: A byte write (`wr_b_en_i`) to register i with data d makes register i read d on port A and port B from the first rising edge after it is presented.
- R3: Reads are combinational: changing a read index changes the read data in the same cycle. A read of a register that is being written in the current cycle returns its old value.
- R4: A word write to pair p updates register 2p with bits [7:0] and register 2p+1 with bits [15:8] on the same edge. A word read of pair p returns {register 2p+1, register 2p}.
- R5: `ptr_x_o` = {r27, r26}, `ptr_y_o` = {r29, r28} and `ptr_z_o` = {r31, r30}, and they follow those registers at all times.
- R6: A data-space access with address below 0x20 targets register `addr[4:0]`. A read returns that register combinationally, and a write updates it on the next edge. Neither `io_en_o` nor `mem_en_o` is raised.
- R7: A data-space access with address from 0x20 to 0x5F raises `io_en_o` and passes `io_we_o`, the write data and `io_addr_o` = address − 0x20. Read data is taken from `io_rdata_i`. No register changes.
- R8: A data-space access with address 0x60 or higher raises `mem_en_o` and passes the full address and the write data unchanged. Read data is taken from `mem_rdata_i`. No register changes.
- R9: When several writes target one register in the same cycle, the byte write wins over the word write, and the word write wins over the data-space write. The byte of a word write that does not collide is still written.
- R10: A register with no write targeting it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Byte read port A register index |
| rd_a_data_o | output | 8 | Byte read port A data |
| rd_b_idx_i | input | 5 | Byte read port B register index |
| rd_b_data_o | output | 8 | Byte read port B data |
| rd_w_idx_i | input | 4 | Word read pair index (registers 2p, 2p+1) |
| rd_w_data_o | output | 16 | Word read data, odd register in the upper byte |
| wr_b_en_i | input | 1 | Byte write enable |
| wr_b_idx_i | input | 5 | Byte write register index |
| wr_b_data_i | input | 8 | Byte write data |
| wr_w_en_i | input | 1 | Word write enable |
| wr_w_pair_i | input | 4 | Word write pair index |
| wr_w_data_i | input | 16 | Word write data |
| ptr_x_o | output | 16 | Pointer from registers 27:26 |
| ptr_y_o | output | 16 | Pointer from registers 29:28 |
| ptr_z_o | output | 16 | Pointer from registers 31:30 |
| ds_en_i | input | 1 | Data-space access request |
| ds_we_i | input | 1 | Data-space write (1) or read (0) |
| ds_addr_i | input | 16 | Data-space address |
| ds_wdata_i | input | 8 | Data-space write data |
| ds_rdata_o | output | 8 | Data-space read data |
| io_en_o | output | 1 | I/O window access strobe |
| io_we_o | output | 1 | I/O write |
| io_addr_o | output | 6 | I/O offset (address − 0x20) |
| io_wdata_o | output | 8 | I/O write data |
| io_rdata_i | input | 8 | I/O read data |
| mem_en_o | output | 1 | Memory-side access strobe |
| mem_we_o | output | 1 | Memory-side write |
| mem_addr_o | output | 16 | Memory-side address |
| mem_wdata_o | output | 8 | Memory-side write data |
| mem_rdata_i | input | 8 | Memory-side read data |

## Verification
Read data, data-space routing strobes and pointer outputs are due in the same cycle as their inputs, so the bench checks them 1 ns after driving on the falling edge, before the next rising edge. Register updates from any write path are due after exactly one rising edge. The bench presents each write on a falling edge, removes it on the next falling edge and only then drains the scoreboard. Each write is therefore observed once the single edge has passed, and no write is active while the read ports are stepped. The old-value case is checked inside the write cycle itself, before the edge.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  typedef enum logic [1:0] {
    DS_TGT_NONE = 2'd0,
    DS_TGT_GPR  = 2'd1,
    DS_TGT_IO   = 2'd2,
    DS_TGT_MEM  = 2'd3
  } ds_target_e;
endpackage

// File: rtl/rf_write_arb.sv
module rf_write_arb #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W  = IDX_W - 1,
  localparam int unsigned WORD_W  = 2 * DATA_W
) (
  input  logic                             b_en_i,
  input  logic [IDX_W-1:0]                 b_idx_i,
  input  logic [DATA_W-1:0]                b_data_i,
  input  logic                             w_en_i,
  input  logic [PAIR_W-1:0]                w_pair_i,
  input  logic [WORD_W-1:0]                w_data_i,
  input  logic                             d_en_i,
  input  logic [IDX_W-1:0]                 d_idx_i,
  input  logic [DATA_W-1:0]                d_data_i,
  output logic [NUM_REGS-1:0]              we_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  wdata_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int unsigned PAIR = r / 2;
    localparam bit          HIGH = (r % 2) == 1;
    logic [DATA_W-1:0] w_byte;
    assign w_byte = HIGH ? w_data_i[WORD_W-1:DATA_W] : w_data_i[DATA_W-1:0];

    // priority: byte port, then word port, then data-space
    always_comb begin
      we_o[r]    = 1'b0;
      wdata_o[r] = '0;
      if (b_en_i && b_idx_i == IDX_W'(r)) begin
        we_o[r]    = 1'b1;
        wdata_o[r] = b_data_i;
      end else if (w_en_i && w_pair_i == PAIR_W'(PAIR)) begin
        we_o[r]    = 1'b1;
        wdata_o[r] = w_byte;
      end else if (d_en_i && d_idx_i == IDX_W'(r)) begin
        we_o[r]    = 1'b1;
        wdata_o[r] = d_data_i;
      end
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              we_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[r] <= '0;
      else if (we_i[r])  q_o[r] <= wdata_i[r];
    end
  end
endmodule

// File: rtl/rf_dspace_decode.sv
module rf_dspace_decode
  import gpr_file_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_COUNT = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned IO_AW    = $clog2(IO_COUNT),
  localparam int unsigned IO_BASE  = NUM_REGS,
  localparam int unsigned MEM_BASE = NUM_REGS + IO_COUNT
) (
  input  logic              ds_en_i,
  input  logic              ds_we_i,
  input  logic [ADDR_W-1:0] ds_addr_i,
  input  logic [DATA_W-1:0] ds_wdata_i,
  output logic [DATA_W-1:0] ds_rdata_o,
  output logic [IDX_W-1:0]  gpr_idx_o,
  output logic              gpr_we_o,
  input  logic [DATA_W-1:0] gpr_rdata_i,
  output logic              io_en_o,
  output logic              io_we_o,
  output logic [IO_AW-1:0]  io_addr_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  ds_target_e        tgt;
  logic [ADDR_W-1:0] io_off;

  always_comb begin
    if (!ds_en_i)                              tgt = DS_TGT_NONE;
    else if (ds_addr_i < ADDR_W'(IO_BASE))     tgt = DS_TGT_GPR;
    else if (ds_addr_i < ADDR_W'(MEM_BASE))    tgt = DS_TGT_IO;
    else                                       tgt = DS_TGT_MEM;
  end

  assign io_off      = ds_addr_i - ADDR_W'(IO_BASE);
  assign gpr_idx_o   = ds_addr_i[IDX_W-1:0];
  assign gpr_we_o    = (tgt == DS_TGT_GPR) && ds_we_i;

  assign io_en_o     = (tgt == DS_TGT_IO);
  assign io_we_o     = io_en_o && ds_we_i;
  assign io_addr_o   = io_off[IO_AW-1:0];
  assign io_wdata_o  = ds_wdata_i;

  assign mem_en_o    = (tgt == DS_TGT_MEM);
  assign mem_we_o    = mem_en_o && ds_we_i;
  assign mem_addr_o  = ds_addr_i;
  assign mem_wdata_o = ds_wdata_i;

  always_comb begin
    unique case (tgt)
      DS_TGT_GPR: ds_rdata_o = gpr_rdata_i;
      DS_TGT_IO:  ds_rdata_o = io_rdata_i;
      DS_TGT_MEM: ds_rdata_o = mem_rdata_i;
      default:    ds_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_COUNT = 64,
  parameter int unsigned PTR_BASE = 26,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W   = IDX_W - 1,
  localparam int unsigned WORD_W   = 2 * DATA_W,
  localparam int unsigned IO_AW    = $clog2(IO_COUNT),
  localparam int unsigned NUM_PTRS = (NUM_REGS - PTR_BASE) / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic [PAIR_W-1:0] rd_w_idx_i,
  output logic [WORD_W-1:0] rd_w_data_o,
  input  logic              wr_b_en_i,
  input  logic [IDX_W-1:0]  wr_b_idx_i,
  input  logic [DATA_W-1:0] wr_b_data_i,
  input  logic              wr_w_en_i,
  input  logic [PAIR_W-1:0] wr_w_pair_i,
  input  logic [WORD_W-1:0] wr_w_data_i,
  output logic [WORD_W-1:0] ptr_x_o,
  output logic [WORD_W-1:0] ptr_y_o,
  output logic [WORD_W-1:0] ptr_z_o,
  input  logic              ds_en_i,
  input  logic              ds_we_i,
  input  logic [ADDR_W-1:0] ds_addr_i,
  input  logic [DATA_W-1:0] ds_wdata_i,
  output logic [DATA_W-1:0] ds_rdata_o,
  output logic              io_en_o,
  output logic              io_we_o,
  output logic [IO_AW-1:0]  io_addr_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0][DATA_W-1:0] wdata;
  logic [NUM_REGS-1:0]             we;
  logic [IDX_W-1:0]                ds_idx;
  logic                            ds_gpr_we;
  logic [NUM_PTRS-1:0][WORD_W-1:0] ptrs;

  rf_dspace_decode #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_COUNT(IO_COUNT)
  ) u_decode (
    .ds_en_i     (ds_en_i),
    .ds_we_i     (ds_we_i),
    .ds_addr_i   (ds_addr_i),
    .ds_wdata_i  (ds_wdata_i),
    .ds_rdata_o  (ds_rdata_o),
    .gpr_idx_o   (ds_idx),
    .gpr_we_o    (ds_gpr_we),
    .gpr_rdata_i (regs[ds_idx]),
    .io_en_o     (io_en_o),
    .io_we_o     (io_we_o),
    .io_addr_o   (io_addr_o),
    .io_wdata_o  (io_wdata_o),
    .io_rdata_i  (io_rdata_i),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  rf_write_arb #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_arb (
    .b_en_i   (wr_b_en_i),
    .b_idx_i  (wr_b_idx_i),
    .b_data_i (wr_b_data_i),
    .w_en_i   (wr_w_en_i),
    .w_pair_i (wr_w_pair_i),
    .w_data_i (wr_w_data_i),
    .d_en_i   (ds_gpr_we),
    .d_idx_i  (ds_idx),
    .d_data_i (ds_wdata_i),
    .we_o     (we),
    .wdata_o  (wdata)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wdata),
    .q_o     (regs)
  );

  assign rd_a_data_o = regs[rd_a_idx_i];
  assign rd_b_data_o = regs[rd_b_idx_i];
  assign rd_w_data_o = {regs[{rd_w_idx_i, 1'b1}], regs[{rd_w_idx_i, 1'b0}]};

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    assign ptrs[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  assign ptr_x_o = ptrs[0];
  assign ptr_y_o = ptrs[1];
  assign ptr_z_o = ptrs[2];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_COUNT = 64,
  parameter int unsigned PTR_BASE = 26,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PAIR_W  = IDX_W - 1,
  localparam int unsigned WORD_W  = 2 * DATA_W,
  localparam int unsigned IO_AW   = $clog2(IO_COUNT)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [IDX_W-1:0]  rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic [PAIR_W-1:0] rd_w_idx_i,
  input logic [WORD_W-1:0] rd_w_data_o,
  input logic              wr_b_en_i,
  input logic [IDX_W-1:0]  wr_b_idx_i,
  input logic [DATA_W-1:0] wr_b_data_i,
  input logic              wr_w_en_i,
  input logic [PAIR_W-1:0] wr_w_pair_i,
  input logic [WORD_W-1:0] wr_w_data_i,
  input logic [WORD_W-1:0] ptr_x_o,
  input logic [WORD_W-1:0] ptr_z_o,
  input logic              ds_en_i,
  input logic              ds_we_i,
  input logic [ADDR_W-1:0] ds_addr_i,
  input logic [DATA_W-1:0] ds_rdata_o,
  input logic              io_en_o,
  input logic [IO_AW-1:0]  io_addr_o,
  input logic              mem_en_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(NUM_REGS + IO_COUNT);

  logic any_write;
  assign any_write = wr_b_en_i || wr_w_en_i || (ds_en_i && ds_we_i);

  a_r2_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_b_en_i |=> (rd_a_idx_i != $past(wr_b_idx_i)) || (rd_a_data_o == $past(wr_b_data_i)));

  a_r4_word_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_w_en_i && !wr_b_en_i && !(ds_en_i && ds_we_i)) |=>
      (rd_w_idx_i != $past(wr_w_pair_i)) || (rd_w_data_o == $past(wr_w_data_i)));

  a_r5_ptr_z_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == IDX_W'(PTR_BASE + 4)) |-> (rd_a_data_o == ptr_z_o[DATA_W-1:0]));

  a_r5_ptr_x_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_idx_i == IDX_W'(PTR_BASE + 1)) |-> (rd_b_data_o == ptr_x_o[WORD_W-1:DATA_W]));

  a_r6_gpr_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_en_i && ds_addr_i < IO_LO) |->
      (!io_en_o && !mem_en_o &&
       ((rd_a_idx_i != ds_addr_i[IDX_W-1:0]) || (ds_rdata_o == rd_a_data_o))));

  a_r7_io_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_en_i && ds_addr_i >= IO_LO && ds_addr_i < MEM_LO) |->
      (io_en_o && !mem_en_o && (ADDR_W'(io_addr_o) == ds_addr_i - IO_LO)));

  a_r8_mem_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_en_i && ds_addr_i >= MEM_LO) |-> (mem_en_o && !io_en_o && mem_addr_o == ds_addr_i));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_write |=> (!$stable(rd_a_idx_i) || $stable(rd_a_data_o)));
endmodule

bind gpr_file gpr_file_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .IO_COUNT(IO_COUNT), .PTR_BASE(PTR_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_idx_i  (rd_b_idx_i),
  .rd_b_data_o (rd_b_data_o),
  .rd_w_idx_i  (rd_w_idx_i),
  .rd_w_data_o (rd_w_data_o),
  .wr_b_en_i   (wr_b_en_i),
  .wr_b_idx_i  (wr_b_idx_i),
  .wr_b_data_i (wr_b_data_i),
  .wr_w_en_i   (wr_w_en_i),
  .wr_w_pair_i (wr_w_pair_i),
  .wr_w_data_i (wr_w_data_i),
  .ptr_x_o     (ptr_x_o),
  .ptr_z_o     (ptr_z_o),
  .ds_en_i     (ds_en_i),
  .ds_we_i     (ds_we_i),
  .ds_addr_i   (ds_addr_i),
  .ds_rdata_o  (ds_rdata_o),
  .io_en_o     (io_en_o),
  .io_addr_o   (io_addr_o),
  .mem_en_o    (mem_en_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/gpr_file_test.sv
`timescale 1ns/1ps
module gpr_file_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [4:0]  rd_a_idx_i, rd_b_idx_i, wr_b_idx_i;
  logic [3:0]  rd_w_idx_i, wr_w_pair_i;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr_b_data_i;
  logic [15:0] rd_w_data_o, wr_w_data_i, ptr_x_o, ptr_y_o, ptr_z_o;
  logic        wr_b_en_i, wr_w_en_i;
  logic        ds_en_i, ds_we_i;
  logic [15:0] ds_addr_i, mem_addr_o;
  logic [7:0]  ds_wdata_i, ds_rdata_o, io_wdata_o, io_rdata_i, mem_wdata_o, mem_rdata_i;
  logic        io_en_o, io_we_o, mem_en_o, mem_we_o;
  logic [5:0]  io_addr_o;

  always #2 clk_i = ~clk_i;

  gpr_file uut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [32];

  typedef struct {
    string       req;
    int          kind;   // 0 port A, 1 port B, 2 word port, 3 pointer, 4 data-space read
    int          idx;
    logic [15:0] val;
  } exp_t;
  exp_t sb [$];

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic push(string req, int kind, int idx, logic [15:0] val);
    exp_t e;
    e.req = req; e.kind = kind; e.idx = idx; e.val = val;
    sb.push_back(e);
  endtask

  // monitor: no write is active while draining
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e;
      logic [15:0] got;
      e = sb.pop_front();
      case (e.kind)
        0: begin rd_a_idx_i = 5'(e.idx); #1 got = {8'h00, rd_a_data_o}; end
        1: begin rd_b_idx_i = 5'(e.idx); #1 got = {8'h00, rd_b_data_o}; end
        2: begin rd_w_idx_i = 4'(e.idx); #1 got = rd_w_data_o; end
        3: begin #1 got = (e.idx == 0) ? ptr_x_o : (e.idx == 1) ? ptr_y_o : ptr_z_o; end
        default: begin
          ds_en_i = 1'b1; ds_we_i = 1'b0; ds_addr_i = 16'(e.idx);
          #1 got = {8'h00, ds_rdata_o};
          ds_en_i = 1'b0;
        end
      endcase
      check(e.req, got, e.val);
    end
  endtask

  task automatic byte_wr(int idx, logic [7:0] d);
    @(negedge clk_i);
    wr_b_en_i = 1'b1; wr_b_idx_i = 5'(idx); wr_b_data_i = d;
    @(negedge clk_i);
    wr_b_en_i = 1'b0;
    model[idx] = d;
  endtask

  task automatic word_wr(int pair, logic [15:0] d);
    @(negedge clk_i);
    wr_w_en_i = 1'b1; wr_w_pair_i = 4'(pair); wr_w_data_i = d;
    @(negedge clk_i);
    wr_w_en_i = 1'b0;
    model[2*pair]   = d[7:0];
    model[2*pair+1] = d[15:8];
  endtask

  task automatic ds_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = a; ds_wdata_i = d;
    @(negedge clk_i);
    ds_en_i = 1'b0; ds_we_i = 1'b0;
    if (a < 16'h20) model[a[4:0]] = d;
  endtask

  function automatic logic [15:0] pair_of(int lo);
    return {model[lo+1], model[lo]};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    rd_a_idx_i = '0; rd_b_idx_i = '0; rd_w_idx_i = '0;
    wr_b_en_i = 1'b0; wr_b_idx_i = '0; wr_b_data_i = '0;
    wr_w_en_i = 1'b0; wr_w_pair_i = '0; wr_w_data_i = '0;
    ds_en_i = 1'b0; ds_we_i = 1'b0; ds_addr_i = '0; ds_wdata_i = '0;
    io_rdata_i = 8'h00; mem_rdata_i = 8'h00;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 32; i++) push("R1", 0, i, 16'h0000);
    for (int p = 0; p < 3; p++) push("R1", 3, p, 16'h0000);
    drain();

    // R2 byte writes, two value patterns
    for (int i = 0; i < 32; i++) byte_wr(i, 8'((i * 37 + 5) & 255));
    for (int i = 0; i < 32; i++) begin
      push("R2", 0, i, {8'h00, model[i]});
      push("R2", 1, 31 - i, {8'h00, model[31 - i]});
    end
    drain();
    for (int i = 0; i < 32; i += 3) byte_wr(i, ~model[i]);
    for (int i = 0; i < 32; i++) push("R2", 1, i, {8'h00, model[i]});
    drain();

    // R3 read of register written this cycle returns old value
    @(negedge clk_i);
    rd_a_idx_i = 5'd4;
    wr_b_en_i = 1'b1; wr_b_idx_i = 5'd4; wr_b_data_i = 8'hC3;
    #1 check("R3 old value", {8'h00, rd_a_data_o}, {8'h00, model[4]});
    rd_a_idx_i = 5'd9;
    #0.5 check("R3 combinational index change", {8'h00, rd_a_data_o}, {8'h00, model[9]});
    rd_a_idx_i = 5'd4;
    @(negedge clk_i);
    wr_b_en_i = 1'b0; model[4] = 8'hC3;
    #1 check("R3 new value after edge", {8'h00, rd_a_data_o}, 16'h00C3);

    // R4 word writes
    word_wr(3, 16'hBEEF);
    word_wr(0, 16'h1234);
    push("R4", 2, 3, 16'hBEEF);
    push("R4", 0, 6, 16'h00EF);
    push("R4", 1, 7, 16'h00BE);
    push("R4", 2, 0, 16'h1234);
    push("R4", 2, 8, pair_of(16));
    drain();

    // R5 pointers
    word_wr(13, 16'hA55A);
    byte_wr(28, 8'h11);
    byte_wr(29, 8'h22);
    word_wr(15, 16'h0F0E);
    push("R5", 3, 0, 16'hA55A);
    push("R5", 3, 1, 16'h2211);
    push("R5", 3, 2, 16'h0F0E);
    drain();

    // R6 register window
    ds_wr(16'h0005, 8'h6D);
    ds_wr(16'h001F, 8'h99);
    push("R6", 0, 5, 16'h006D);
    push("R6", 4, 31, 16'h0099);
    push("R6", 4, 6, {8'h00, model[6]});
    push("R5", 3, 2, 16'h990E);
    drain();
    @(negedge clk_i);
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = 16'h0010; ds_wdata_i = 8'h3C;
    #1 check("R6 io_en low", {15'd0, io_en_o}, 16'd0);
    check("R6 mem_en low", {15'd0, mem_en_o}, 16'd0);
    @(negedge clk_i);
    ds_en_i = 1'b0; ds_we_i = 1'b0; model[16] = 8'h3C;
    push("R6", 0, 16, 16'h003C);
    drain();

    // R7 I/O window, both ends
    @(negedge clk_i);
    io_rdata_i = 8'h5A;
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = 16'h0025; ds_wdata_i = 8'h77;
    #1 check("R7 io_en", {15'd0, io_en_o}, 16'd1);
    check("R7 io_we", {15'd0, io_we_o}, 16'd1);
    check("R7 io_addr", {10'd0, io_addr_o}, 16'h0005);
    check("R7 io_wdata", {8'h00, io_wdata_o}, 16'h0077);
    check("R7 mem_en", {15'd0, mem_en_o}, 16'd0);
    check("R7 rdata", {8'h00, ds_rdata_o}, 16'h005A);
    @(negedge clk_i);
    ds_we_i = 1'b0; ds_addr_i = 16'h005F;
    #1 check("R7 top io_addr", {10'd0, io_addr_o}, 16'h003F);
    check("R7 read io_we", {15'd0, io_we_o}, 16'd0);
    @(negedge clk_i);
    ds_addr_i = 16'h0020;
    #1 check("R7 base io_addr", {10'd0, io_addr_o}, 16'h0000);
    @(negedge clk_i);
    ds_en_i = 1'b0;
    push("R7", 0, 5, {8'h00, model[5]});
    drain();

    // R8 memory-side window
    @(negedge clk_i);
    mem_rdata_i = 8'hE1;
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = 16'h0060; ds_wdata_i = 8'h42;
    #1 check("R8 mem_en", {15'd0, mem_en_o}, 16'd1);
    check("R8 mem_we", {15'd0, mem_we_o}, 16'd1);
    check("R8 mem_addr", mem_addr_o, 16'h0060);
    check("R8 mem_wdata", {8'h00, mem_wdata_o}, 16'h0042);
    check("R8 io_en", {15'd0, io_en_o}, 16'd0);
    check("R8 rdata", {8'h00, ds_rdata_o}, 16'h00E1);
    @(negedge clk_i);
    ds_addr_i = 16'hFFFF;
    #1 check("R8 high mem_addr", mem_addr_o, 16'hFFFF);
    @(negedge clk_i);
    ds_en_i = 1'b0; ds_we_i = 1'b0;
    push("R8", 0, 0, {8'h00, model[0]});
    drain();

    // R9 collisions
    @(negedge clk_i);
    wr_b_en_i = 1'b1; wr_b_idx_i = 5'd8; wr_b_data_i = 8'hB8;
    wr_w_en_i = 1'b1; wr_w_pair_i = 4'd4; wr_w_data_i = 16'h9988;
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = 16'h0008; ds_wdata_i = 8'hD8;
    @(negedge clk_i);
    wr_b_en_i = 1'b0; wr_w_en_i = 1'b0; ds_en_i = 1'b0; ds_we_i = 1'b0;
    push("R9 byte wins", 0, 8, 16'h00B8);
    push("R9 word other byte", 0, 9, 16'h0099);
    drain();
    @(negedge clk_i);
    wr_w_en_i = 1'b1; wr_w_pair_i = 4'd5; wr_w_data_i = 16'h5150;
    ds_en_i = 1'b1; ds_we_i = 1'b1; ds_addr_i = 16'h000A; ds_wdata_i = 8'hDD;
    @(negedge clk_i);
    wr_w_en_i = 1'b0; ds_en_i = 1'b0; ds_we_i = 1'b0;
    model[8] = 8'hB8; model[9] = 8'h99; model[10] = 8'h50; model[11] = 8'h51;
    push("R9 word beats data-space", 0, 10, 16'h0050);
    push("R9 word high", 0, 11, 16'h0051);
    drain();

    // R10 idle cycles change nothing
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 32; i++) push("R10", 0, i, {8'h00, model[i]});
    drain();

    finish_run();
  end
endmodule